// File: doc/BRIEF.md
# Write-Protected Two-Level Pin Multiplexer

This block holds the routing configuration for a row of device pins. Each pin owns one configuration word in a first-level bank and one in a second-level bank. The first-level word carries a 4-bit function selector, a pull setting and a drive-strength code. A selector of 10 or more hands the choice to the second-level word, which names one of a larger set of functions. The block turns the two words into one resolved function number per pin and drives it, together with the pull and drive codes, to the pad logic. The second-level bank also holds two small registers that pick the source of each of two management-data channels.

Both banks are guarded by a write lock. A bank is opened or closed only by writing its own protect-register bus address into that register, with bit 0 as the open flag. While a bank is closed, its configuration writes are dropped. Software reaches everything through one word-wide bus port: an address, write data, a write strobe, and combinational read data. The bank base addresses are parameters and must be 4 KiB aligned.

Top module: `pin_route_ctrl`

## Requirements
- R1: After reset both banks are locked, every pin word and both channel selects read as zero, and every pin drives function 0, pull 0 and drive 0.
- R2: A write to a bank's protect register (base + 0x400) whose data equals that register's own byte address in bits 31:1 sets the lock to the inverse of data bit 0. Reading the protect register returns 1 in bit 0 when locked and 0 when open. The two banks lock independently.
- R3: A protect write whose data bits 31:1 differ from the register's own address leaves the lock unchanged.
- R4: While a bank is locked, writes to its pin words and, in the second-level bank, to its channel selects change neither the stored value nor any output.
- R5: A first-level pin word (base + 4*pin) keeps function in bits 3:0, pull in bits 9:8 (0 none, 1 up, 3 down) and drive in bits 11:10 (0..3 meaning 4, 6, 8, 12 mA). All other bits read back as zero. The pull and drive outputs carry these codes unchanged.
- R6: A second-level pin word keeps a 6-bit value in bits 5:0; all other bits read back as zero.
- R7: The resolved function is the first-level selector when it is below 10, and otherwise 10 plus the pin's second-level value (for example, selector 15 with value 61 gives 71).
- R8: The channel select registers sit at second-level base + 0x404 (channel 0) and + 0x408 (channel 1). Each keeps 3 bits, where 0 means floating and 1..7 name a source. Channel c drives mdio_src bits 3c+2:3c.
- R9: Writes to pin offsets at or past the pin count, to other unused offsets in a bank, to addresses with bits 1:0 nonzero, or to addresses outside both banks are discarded, and reads of them return zero.
- R10: Read data follows the address in the same cycle. A write is visible on read data and on the pin outputs from the clock edge that samples the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_func | output | 7*NUM_PINS | Resolved function number, pin p at bits 7p+6:7p |
| pin_pull | output | 2*NUM_PINS | Pull code, pin p at bits 2p+1:2p |
| pin_drive | output | 2*NUM_PINS | Drive-strength code, pin p at bits 2p+1:2p |
| mdio_src | output | 6 | Source select of the two management-data channels |

## Verification
Read data is combinational, so the bench compares it about one time unit after it changes the address, in the same cycle. Every register sits one edge from its result. The bench raises a write strobe at a falling edge and releases it at the next falling edge. It expects the pin outputs and the read data to show the new value after the rising edge between them. To confirm that nothing appears early, it checks once, just before that edge, that the outputs still hold the old value. A reference model in the bench applies each write at that same edge, including the lock state, and predicts every read and every pin output.

// File: rtl/pin_route_pkg.sv
// Package: constants shared by the pin-routing controller.
// Assumes bank bases are 4 KiB aligned and word offsets fit in address bits 11:2.
package pin_route_pkg;
    localparam int          WORD_IDX_W  = 10;        // address bits 11:2
    localparam logic [9:0]  PROT_IDX    = 10'h100;   // byte offset 0x400
    localparam int          L1_STORE_W  = 8;         // function 4 + pull 2 + drive 2
    localparam int          L2_STORE_W  = 6;         // second-level value
    localparam int          FUNC_W      = 7;         // resolved function, up to 73
    localparam int          MDIO_W      = 3;
    localparam int          MDIO_CH     = 2;
    localparam logic [3:0]  DIRECT_LIMIT = 4'd10;    // selectors below this are direct
endpackage

// File: rtl/pin_route_bank.sv
// Module: one configuration bank with per-pin words and a self-addressed write lock.
// LEVEL 1 keeps function/pull/drive fields; LEVEL 2 keeps a 6-bit value.
// Assumes BASE is 4 KiB aligned; accesses with address bits 1:0 nonzero are ignored.
module pin_route_bank
    import pin_route_pkg::*;
#(
    parameter logic [31:0] BASE     = 32'h4006_7000,
    parameter int          NUM_PINS = 170,
    parameter int          LEVEL    = 1,
    localparam int         STORE_W  = (LEVEL == 1) ? L1_STORE_W : L2_STORE_W
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [31:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic                        bus_we,
    output logic [31:0]                 rd_data,
    output logic [NUM_PINS*STORE_W-1:0] words_q,
    output logic                        locked
);
    localparam logic [31:0] PROT_ADDR = BASE + 32'h400;

    logic                  hit;
    logic [WORD_IDX_W-1:0] idx;
    logic                  key_ok;
    logic                  prot_wr;
    logic [STORE_W-1:0]    wr_pack;
    logic [STORE_W-1:0]    word_r [NUM_PINS];
    logic [31:0]           pin_rd [NUM_PINS];

    assign hit     = (bus_addr[31:12] == BASE[31:12]) && (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[11:2];
    assign key_ok  = (bus_wdata[31:1] == PROT_ADDR[31:1]);
    assign prot_wr = bus_we && hit && (idx == PROT_IDX);

    // Lock register: opened or closed only by writing the register's own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (prot_wr && key_ok)
            locked <= ~bus_wdata[0];
    end

    genvar i;
    generate
        if (LEVEL == 1) begin : g_level1
            assign wr_pack = {bus_wdata[11:8], bus_wdata[3:0]};
            for (i = 0; i < NUM_PINS; i++) begin : g_rd
                assign pin_rd[i] = {20'b0, word_r[i][7:4], 4'b0, word_r[i][3:0]};
            end
        end else begin : g_level2
            assign wr_pack = bus_wdata[5:0];
            for (i = 0; i < NUM_PINS; i++) begin : g_rd
                assign pin_rd[i] = {26'b0, word_r[i]};
            end
        end

        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            // Pin word: written only while the bank is open.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_r[i] <= '0;
                else if (bus_we && hit && !locked && (idx == WORD_IDX_W'(i)))
                    word_r[i] <= wr_pack;
            end
            assign words_q[i*STORE_W +: STORE_W] = word_r[i];
        end
    endgenerate

    // Read mux: pin words, lock state, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (hit) begin
            if (idx == PROT_IDX)
                rd_data = {31'b0, locked};
            for (int p = 0; p < NUM_PINS; p++)
                if (idx == WORD_IDX_W'(p))
                    rd_data = pin_rd[p];
        end
    end

    AST_LOCKED_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(words_q)); // R4
    AST_FOREIGN_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && (idx == PROT_IDX) && (bus_wdata[31:1] != PROT_ADDR[31:1]))
        |=> $stable(locked)); // R3
    AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bus_we && bus_wdata[0] && (bus_wdata[31:1] == PROT_ADDR[31:1]))); // R2
endmodule

// File: rtl/pin_route_mdio.sv
// Module: the two management-data channel source selects of the second-level bank.
// Assumes BASE is the second-level bank base; writes follow that bank's lock.
module pin_route_mdio
    import pin_route_pkg::*;
#(
    parameter logic [31:0] BASE = 32'h4006_8000
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [31:0]               bus_addr,
    input  logic [MDIO_W-1:0]         bus_wsel,
    input  logic                      bus_we,
    input  logic                      bank_locked,
    output logic [31:0]               rd_data,
    output logic [MDIO_CH*MDIO_W-1:0] sel_q
);
    logic                  hit;
    logic [WORD_IDX_W-1:0] idx;

    assign hit = (bus_addr[31:12] == BASE[31:12]) && (bus_addr[1:0] == 2'b00);
    assign idx = bus_addr[11:2];

    genvar c;
    generate
        for (c = 0; c < MDIO_CH; c++) begin : g_ch
            // Channel select: written only while the bank is open.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sel_q[c*MDIO_W +: MDIO_W] <= '0;
                else if (bus_we && hit && !bank_locked && (idx == PROT_IDX + WORD_IDX_W'(c + 1)))
                    sel_q[c*MDIO_W +: MDIO_W] <= bus_wsel;
            end
        end
    endgenerate

    // Read mux for the channel selects.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < MDIO_CH; k++)
            if (hit && (idx == PROT_IDX + WORD_IDX_W'(k + 1)))
                rd_data = {29'b0, sel_q[k*MDIO_W +: MDIO_W]};
    end

    AST_MDIO_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_locked |=> $stable(sel_q)); // R4
endmodule

// File: rtl/pin_route_resolve.sv
// Module: per-pin function resolution from the two bank words.
// Assumes selectors of 10 and above all defer to the second level.
module pin_route_resolve
    import pin_route_pkg::*;
(
    input  logic [3:0]        l1_sel,
    input  logic [1:0]        l1_pull,
    input  logic [1:0]        l1_drive,
    input  logic [5:0]        l2_val,
    output logic [FUNC_W-1:0] func,
    output logic [1:0]        pull,
    output logic [1:0]        drive
);
    // Pick a direct function or the offset second-level one.
    always_comb begin
        if (l1_sel < DIRECT_LIMIT)
            func = FUNC_W'(l1_sel);
        else
            func = FUNC_W'(DIRECT_LIMIT) + FUNC_W'(l2_val);
    end

    assign pull  = l1_pull;
    assign drive = l1_drive;
endmodule

// File: rtl/pin_route_ctrl.sv
// Module: top of the write-protected two-level pin multiplexer.
// Assumes the two bank bases are distinct and 4 KiB aligned.
module pin_route_ctrl
    import pin_route_pkg::*;
#(
    parameter int          NUM_PINS = 170,
    parameter logic [31:0] L1_BASE  = 32'h4006_7000,
    parameter logic [31:0] L2_BASE  = 32'h4006_8000
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [31:0]                bus_addr,
    input  logic [31:0]                bus_wdata,
    input  logic                       bus_we,
    output logic [31:0]                bus_rdata,
    output logic [NUM_PINS*FUNC_W-1:0] pin_func,
    output logic [NUM_PINS*2-1:0]      pin_pull,
    output logic [NUM_PINS*2-1:0]      pin_drive,
    output logic [MDIO_CH*MDIO_W-1:0]  mdio_src
);
    logic [NUM_PINS*L1_STORE_W-1:0] l1_words;
    logic [NUM_PINS*L2_STORE_W-1:0] l2_words;
    logic [31:0] l1_rd, l2_rd, md_rd;
    logic        l1_locked, l2_locked;

    pin_route_bank #(.BASE(L1_BASE), .NUM_PINS(NUM_PINS), .LEVEL(1)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .rd_data(l1_rd), .words_q(l1_words), .locked(l1_locked)
    );

    pin_route_bank #(.BASE(L2_BASE), .NUM_PINS(NUM_PINS), .LEVEL(2)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .rd_data(l2_rd), .words_q(l2_words), .locked(l2_locked)
    );

    pin_route_mdio #(.BASE(L2_BASE)) u_mdio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wsel(bus_wdata[MDIO_W-1:0]),
        .bus_we(bus_we), .bank_locked(l2_locked), .rd_data(md_rd), .sel_q(mdio_src)
    );

    // Each source returns zero unless addressed, so the read path is an OR.
    assign bus_rdata = l1_rd | l2_rd | md_rd;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_res
            pin_route_resolve u_res (
                .l1_sel  (l1_words[p*L1_STORE_W     +: 4]),
                .l1_pull (l1_words[p*L1_STORE_W + 4 +: 2]),
                .l1_drive(l1_words[p*L1_STORE_W + 6 +: 2]),
                .l2_val  (l2_words[p*L2_STORE_W     +: 6]),
                .func    (pin_func[p*FUNC_W +: FUNC_W]),
                .pull    (pin_pull[p*2 +: 2]),
                .drive   (pin_drive[p*2 +: 2])
            );
        end
    endgenerate

    AST_RESET_LEAVES_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (l1_locked && l2_locked)); // R1
endmodule

// File: tb/pin_route_ctrl_test.sv
module pin_route_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          NP         = 6;
    localparam logic [31:0] B1 = 32'h4006_7000;
    localparam logic [31:0] B2 = 32'h4006_8000;
    localparam logic [31:0] P1 = B1 + 32'h400;
    localparam logic [31:0] P2 = B2 + 32'h400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [NP*7-1:0] pin_func;
    logic [NP*2-1:0] pin_pull, pin_drive;
    logic [5:0] mdio_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [11:0] m1 [NP];
    logic [5:0]  m2 [NP];
    logic [2:0]  md [2];
    logic        lk1, lk2;

    pin_route_ctrl #(.NUM_PINS(NP), .L1_BASE(B1), .L2_BASE(B2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_func(pin_func),
        .pin_pull(pin_pull), .pin_drive(pin_drive), .mdio_src(mdio_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        int idx = int'(a[11:2]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a[31:12] == B1[31:12]) begin
            if (idx < NP) return {20'b0, m1[idx]};
            if (idx == 256) return {31'b0, lk1};
        end else if (a[31:12] == B2[31:12]) begin
            if (idx < NP) return {26'b0, m2[idx]};
            if (idx == 256) return {31'b0, lk2};
            if (idx == 257) return {29'b0, md[0]};
            if (idx == 258) return {29'b0, md[1]};
        end
        return 32'h0;
    endfunction

    function automatic logic [6:0] exp_func(input int p);
        if (m1[p][3:0] < 4'd10) return {3'b0, m1[p][3:0]};
        return 7'd10 + {1'b0, m2[p]};
    endfunction

    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        int idx = int'(a[11:2]);
        if (a[1:0] != 2'b00) return;
        if (a[31:12] == B1[31:12]) begin
            if (idx == 256 && d[31:1] == P1[31:1]) lk1 = ~d[0];
            else if (idx < NP && !lk1) m1[idx] = d[11:0] & 12'hF0F;
        end else if (a[31:12] == B2[31:12]) begin
            if (idx == 256 && d[31:1] == P2[31:1]) lk2 = ~d[0];
            else if (idx < NP && !lk2) m2[idx] = d[5:0];
            else if (idx == 257 && !lk2) md[0] = d[2:0];
            else if (idx == 258 && !lk2) md[1] = d[2:0];
        end
    endtask

    // Strobe raised at a falling edge, taken at the rising edge, released at the next fall.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic out_chk(input string req);
        for (int p = 0; p < NP; p++) begin
            chk({req, " func"},  {25'b0, pin_func[p*7 +: 7]},  {25'b0, exp_func(p)});
            chk({req, " pull"},  {30'b0, pin_pull[p*2 +: 2]},  {30'b0, m1[p][9:8]});
            chk({req, " drive"}, {30'b0, pin_drive[p*2 +: 2]}, {30'b0, m1[p][11:10]});
        end
        chk({req, " mdio"}, {26'b0, mdio_src}, {26'b0, md[1], md[0]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) begin m1[p] = '0; m2[p] = '0; end
        md[0] = '0; md[1] = '0; lk1 = 1'b1; lk2 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 l1 protect", P1);
        rd_chk("R1 l2 protect", P2);
        rd_chk("R1 l1 pin0", B1);
        rd_chk("R1 mdio0", B2 + 32'h404);
        out_chk("R1 outputs");

        // R4 locked write dropped
        wr(B1 + 4, 32'h0000_0F03);
        rd_chk("R4 locked l1 word", B1 + 4);
        out_chk("R4 locked outputs");

        // R3 wrong key leaves lock closed
        wr(P1, 32'h1234_0401);
        rd_chk("R3 foreign key", P1);
        wr(P1, P1 | 32'h8000_0001);
        rd_chk("R3 upper bit differs", P1);

        // R2 unlock level 1 only
        wr(P1, P1 | 32'h1);
        rd_chk("R2 l1 open", P1);
        rd_chk("R2 l2 still locked", P2);

        // R5 field layout and R7 deferral with zero second level
        wr(B1 + 4, 32'hFFFF_FFFF);
        rd_chk("R5 l1 readback mask", B1 + 4);
        out_chk("R5 R7 all ones");

        // R4 second level still locked
        wr(B2 + 4, 32'd61);
        rd_chk("R4 l2 locked word", B2 + 4);
        wr(P2, P2 | 32'h1);
        wr(B2 + 4, 32'hFFFF_FFC0 | 32'd61);
        rd_chk("R6 l2 readback", B2 + 4);
        chk("R7 sel15 val61", {25'b0, pin_func[1*7 +: 7]}, 32'd71);

        // R5 pull up, drive code 1, direct function 7; R7 direct
        wr(B1 + 8, 32'h0000_0507);
        chk("R5 pull up", {30'b0, pin_pull[2*2 +: 2]}, 32'd1);
        chk("R5 drive 6mA", {30'b0, pin_drive[2*2 +: 2]}, 32'd1);
        chk("R7 direct 7", {25'b0, pin_func[2*7 +: 7]}, 32'd7);
        // R7 boundary: selector 9 direct, 10 deferred
        wr(B1 + 12, 32'h0000_0009);
        chk("R7 selector 9", {25'b0, pin_func[3*7 +: 7]}, 32'd9);
        wr(B2 + 12, 32'd4);
        wr(B1 + 12, 32'h0000_0B0A);
        chk("R7 selector 10", {25'b0, pin_func[3*7 +: 7]}, 32'd14);
        chk("R5 pull down", {30'b0, pin_pull[3*2 +: 2]}, 32'd3);

        // R8 channel selects
        wr(B2 + 32'h404, 32'd5);
        wr(B2 + 32'h408, 32'hFFFF_FFFF);
        rd_chk("R8 mdio0", B2 + 32'h404);
        rd_chk("R8 mdio1", B2 + 32'h408);
        chk("R8 mdio out", {26'b0, mdio_src}, {26'b0, 3'd7, 3'd5});

        // R9 discarded addresses
        wr(B1 + NP*4, 32'h0000_0F05);
        rd_chk("R9 past last pin", B1 + NP*4);
        wr(B1 + 32'h800, 32'hFFFF_FFFF);
        rd_chk("R9 gap", B1 + 32'h800);
        wr(B1 + 32'h011, 32'h0000_0003);
        rd_chk("R9 misaligned", B1 + 32'h010);
        rd_chk("R9 outside", 32'h4006_9000);
        out_chk("R9 outputs");

        // R10 not visible before the sampling edge
        @(negedge clk);
        bus_addr = B1; bus_wdata = 32'h0000_0008; bus_we = 1'b1;
        #1;
        chk("R10 before edge func", {25'b0, pin_func[6:0]}, {25'b0, exp_func(0)});
        chk("R10 before edge read", bus_rdata, exp_read(B1));
        @(posedge clk);
        model_write(B1, 32'h0000_0008);
        @(negedge clk);
        bus_we = 1'b0;
        chk("R10 after edge func", {25'b0, pin_func[6:0]}, 32'd8);

        // R2 relock level 1
        wr(P1, P1);
        rd_chk("R2 relocked", P1);
        wr(B1, 32'h0000_0001);
        rd_chk("R4 relocked word", B1);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [31:0] base, a, d;
            int kind;
            base = ($urandom % 3 == 0) ? B1 : (($urandom % 5 == 0) ? 32'h4006_A000 : B2);
            kind = int'($urandom % 6);
            d = $urandom;
            case (kind)
                0, 1: a = base + 32'(($urandom % (NP + 2)) * 4);
                2: begin a = base + 32'h400; if ($urandom % 4 != 0) d = {a[31:1], d[0]}; end
                3: a = base + 32'h404;
                4: a = base + 32'h408;
                default: a = base + 32'h600;
            endcase
            wr(a, d);
            rd_chk("R9 R4 random read", a);
            rd_chk("R2 random lock", base + 32'h400);
            out_chk("R7 random outputs");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule